// File: doc/BRIEF.md
# Vertical Line Pixel Sequencer

This block turns a request for a one-pixel-wide vertical line into a stream of pixel coordinates, one per clock, for a framebuffer writer that sits downstream. A line is given by its top pixel (a column and a row) and a height in pixels taken at run time. The sequencer walks down the column from the top pixel. Each cycle that carries a pixel raises a draw strobe, and the final pixel of the line also carries a one-cycle done pulse.

The request is a level on `start`. The block takes a request only when it is idle and `start` has been seen low since the last request it took. Holding `start` high therefore yields exactly one line. The column, row and height are latched when the request is taken, so the requester may change them as soon as the next cycle. The pixel count sits in a down-counter and is not unrolled into states, so any height up to 2^H_W-1 uses the same small controller. A height of zero is legal. It yields a done pulse with no pixels, so a requester waiting on done never stalls.

Top module: `vline_seq`

## Requirements
- R1: While reset is applied, and after it is released with no request, `draw` and `done` are low.
- R2: A request is taken on a clock edge where the block is idle, `start` is high, and `start` was sampled low at some edge since the previous request was taken. The first pixel is driven in the cycle right after that edge, at (`x_in`, `y_in`).
- R3: A line of height H ≥ 1 gives exactly H consecutive cycles with `draw` high. `x_out` holds the latched column, and `y_out` rises by one each cycle from the latched row.
- R4: `done` is high for exactly one cycle per request, and for H ≥ 1 that cycle is the one carrying the last pixel. After it, `draw` is low.
- R5: A request with height 0 gives no `draw` cycle and raises `done` for one cycle, in the cycle right after the request is taken.
- R6: `x_in`, `y_in` and `height` are sampled only on the edge where the request is taken. Later changes do not affect the line in progress.
- R7: Keeping `start` high after a request, or holding it high through and after reset, starts no further line until `start` has been sampled low.
- R8: Toggling `start` while a line is in progress neither cuts the line short nor restarts it.
- R9: The row arithmetic wraps modulo 2^Y_W: a line that runs past the last row continues from row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Line request level |
| x_in | input | X_W (9) | Column of the line |
| y_in | input | Y_W (8) | Top row of the line |
| height | input | H_W (8) | Number of pixels in the line |
| x_out | output | X_W (9) | Column of the current pixel |
| y_out | output | Y_W (8) | Row of the current pixel |
| draw | output | 1 | Current coordinate is a valid pixel |
| done | output | 1 | One-cycle pulse marking the end of a request |

## Verification
The bench builds the block with its default widths: a 9-bit column, an 8-bit row and an 8-bit height. At these widths the largest height of 255 can be run to completion, and a line started near row 255 can be driven across the row wrap. Both the zero-height case and the top of the counter range are therefore covered. A behavioural model predicts `draw`, `done` and the coordinates on every cycle. Directed sequences exercise the level-release rule around reset, during a line and between back-to-back requests.

// File: rtl/vline_pkg.sv
package vline_pkg;

  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_RUN   = 2'd1,
    LS_EMPTY = 2'd2
  } lstate_e;

endpackage

// File: rtl/vline_rst_sync.sv
module vline_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ni = sync_q[STAGES-1];

endmodule

// File: rtl/vline_start_gate.sv
module vline_start_gate (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  input  logic idle,
  output logic accept
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  assign accept = idle & start & armed_q;

  always_comb begin
    armed_en = 1'b0;
    armed_d  = armed_q;
    if (accept) begin
      armed_en = 1'b1;
      armed_d  = 1'b0;
    end else if (!start) begin
      armed_en = 1'b1;
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  AST_REARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept ##1 start) |-> !accept); // R7

endmodule

// File: rtl/vline_ctrl.sv
module vline_ctrl
  import vline_pkg::*;
#(
  parameter int H_W = 8
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           accept,
  input  logic [H_W-1:0] height,
  output logic           idle,
  output logic           run,
  output logic           last,
  output logic           empty
);

  localparam logic [H_W-1:0] CNT_ONE = H_W'(1);

  lstate_e        state_q;
  lstate_e        state_d;
  logic [H_W-1:0] cnt_q;
  logic [H_W-1:0] cnt_d;
  logic           cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      LS_IDLE: begin
        if (accept) begin
          cnt_en  = 1'b1;
          cnt_d   = height;
          state_d = (height == '0) ? LS_EMPTY : LS_RUN;
        end
      end
      LS_RUN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - CNT_ONE;
        if (cnt_q == CNT_ONE) begin
          state_d = LS_IDLE;
        end
      end
      LS_EMPTY: begin
        state_d = LS_IDLE;
      end
      default: begin
        state_d = LS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle  = (state_q == LS_IDLE);
  assign run   = (state_q == LS_RUN);
  assign empty = (state_q == LS_EMPTY);
  assign last  = run && (cnt_q == CNT_ONE);

  AST_RUN_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    run |-> (cnt_q != '0)); // R3

  AST_EMPTY_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    empty |=> idle); // R5

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> !idle); // R2

endmodule

// File: rtl/vline_coord.sv
module vline_coord #(
  parameter int X_W = 9,
  parameter int Y_W = 8
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           load,
  input  logic           step,
  input  logic [X_W-1:0] x_in,
  input  logic [Y_W-1:0] y_in,
  output logic [X_W-1:0] x_out,
  output logic [Y_W-1:0] y_out
);

  localparam logic [Y_W-1:0] ROW_STEP = Y_W'(1);

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic [Y_W-1:0] y_d;
  logic           y_en;

  always_comb begin
    y_en = load | step;
    y_d  = load ? y_in : (y_q + ROW_STEP);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
    end else if (load) begin
      x_q <= x_in;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q <= '0;
    end else if (y_en) begin
      y_q <= y_d;
    end
  end

  assign x_out = x_q;
  assign y_out = y_q;

endmodule

// File: rtl/vline_seq.sv
module vline_seq #(
  parameter int X_W = 9,
  parameter int Y_W = 8,
  parameter int H_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [X_W-1:0] x_in,
  input  logic [Y_W-1:0] y_in,
  input  logic [H_W-1:0] height,
  output logic [X_W-1:0] x_out,
  output logic [Y_W-1:0] y_out,
  output logic           draw,
  output logic           done
);

  logic rst_ni;
  logic accept;
  logic idle;
  logic run;
  logic last;
  logic empty;

  vline_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  vline_start_gate u_gate (
    .clk    (clk),
    .rst_ni (rst_ni),
    .start  (start),
    .idle   (idle),
    .accept (accept)
  );

  vline_ctrl #(.H_W(H_W)) u_ctrl (
    .clk    (clk),
    .rst_ni (rst_ni),
    .accept (accept),
    .height (height),
    .idle   (idle),
    .run    (run),
    .last   (last),
    .empty  (empty)
  );

  vline_coord #(.X_W(X_W), .Y_W(Y_W)) u_coord (
    .clk    (clk),
    .rst_ni (rst_ni),
    .load   (accept),
    .step   (run),
    .x_in   (x_in),
    .y_in   (y_in),
    .x_out  (x_out),
    .y_out  (y_out)
  );

  assign draw = run;
  assign done = last | empty;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R4

  AST_DRAW_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && draw) |=> !draw); // R4

  AST_COLUMN_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (draw && $past(draw)) |-> $stable(x_out)); // R3

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (draw && $past(draw)) |-> (y_out == Y_W'($past(y_out) + 1))); // R9

  AST_NO_OUTPUT_IN_RESET: assert property (@(posedge clk)
    !rst_ni |-> (!draw && !done)); // R1

endmodule

// File: tb/vline_seq_tb.sv
module vline_seq_tb;

  localparam int X_W = 9;
  localparam int Y_W = 8;
  localparam int H_W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [X_W-1:0] x_in = '0;
  logic [Y_W-1:0] y_in = '0;
  logic [H_W-1:0] height = '0;
  logic [X_W-1:0] x_out;
  logic [Y_W-1:0] y_out;
  logic           draw;
  logic           done;

  always #4 clk = ~clk;

  vline_seq #(.X_W(X_W), .Y_W(Y_W), .H_W(H_W)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .x_in   (x_in),
    .y_in   (y_in),
    .height (height),
    .x_out  (x_out),
    .y_out  (y_out),
    .draw   (draw),
    .done   (done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int n_draw  = 0;
  int n_done  = 0;
  int last_y  = 0;
  bit finished = 1'b0;

  // behavioural reference model
  int m_st = 0;     // 0 idle, 1 drawing, 2 empty request
  int m_cnt = 0;
  int m_x = 0;
  int m_y = 0;
  int m_rs = 2;
  bit m_armed = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit e_draw;
    bit e_done;
    if (!rst_n) begin
      m_rs = 2; m_st = 0; m_armed = 1'b0;
    end else if (m_rs > 0) begin
      m_rs--;
    end else begin
      case (m_st)
        0: if (start && m_armed) begin
             m_x = int'(x_in); m_y = int'(y_in); m_cnt = int'(height);
             m_st = (height == 0) ? 2 : 1;
             m_armed = 1'b0;
           end
        1: begin
             if (m_cnt == 1) m_st = 0;
             m_cnt--;
             m_y = (m_y + 1) % 256;
           end
        default: m_st = 0;
      endcase
      if (!start) m_armed = 1'b1;
    end
    e_draw = (m_st == 1);
    e_done = (m_st == 1 && m_cnt == 1) || (m_st == 2);
    #2;
    chk(draw == e_draw, "R3 draw", int'(draw), int'(e_draw));
    chk(done == e_done, "R4 done", int'(done), int'(e_done));
    if (e_draw && draw) begin
      chk(int'(x_out) == m_x, "R6 x_out", int'(x_out), m_x);
      chk(int'(y_out) == m_y, "R3 y_out", int'(y_out), m_y);
    end
    if (draw) n_draw++;
    if (done) begin n_done++; last_y = int'(y_out); end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(input int x, input int y, input int h);
    @(negedge clk);
    x_in = X_W'(x); y_in = Y_W'(y); height = H_W'(h); start = 1'b1;
    n_draw = 0; n_done = 0;
  endtask

  task automatic drop();
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    cyc(3);
    @(posedge clk); #2;
    chk(!draw && !done, "R1 in reset", int'(draw | done), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(6);
    chk(!draw && !done, "R1 after release", int'(draw | done), 0);

    // R2 / R3 / R4: basic line
    req(100, 50, 6);
    @(posedge clk); #2;
    chk(draw && y_out == 8'd50 && x_out == 9'd100, "R2 first pixel", int'(y_out), 50);
    cyc(10);
    chk(n_draw == 6, "R3 pixel count", n_draw, 6);
    chk(n_done == 1, "R4 one done", n_done, 1);
    chk(last_y == 55, "R4 done on last pixel", last_y, 55);
    // R7: start still held high
    n_draw = 0; n_done = 0;
    cyc(12);
    chk(n_draw == 0 && n_done == 0, "R7 held start", n_draw + n_done, 0);
    drop();

    // R5: zero height
    req(30, 40, 0);
    @(posedge clk); #2;
    chk(done && !draw, "R5 done next cycle", int'({draw, done}), 1);
    cyc(5);
    chk(n_draw == 0 && n_done == 1, "R5 no pixels", n_draw, 0);
    drop();

    // R6: inputs changed after acceptance
    req(7, 10, 5);
    @(negedge clk);
    x_in = 9'd300; y_in = 8'd200; height = 8'd90;
    cyc(8);
    chk(n_draw == 5, "R6 height latched", n_draw, 5);
    chk(last_y == 14, "R6 row latched", last_y, 14);
    drop();

    // R8: start toggles while busy
    req(1, 0, 20);
    cyc(3);
    start = 1'b0;
    cyc(2);
    start = 1'b1;
    cyc(2);
    start = 1'b0;
    cyc(20);
    chk(n_draw == 20 && n_done == 1, "R8 line unbroken", n_draw, 20);

    // R9: row wrap at far column
    req(511, 250, 10);
    drop();
    cyc(14);
    chk(last_y == 3, "R9 wrapped row", last_y, 3);
    chk(n_draw == 10, "R9 pixel count", n_draw, 10);

    // R3: full counter range
    req(2, 0, 255);
    drop();
    cyc(262);
    chk(n_draw == 255 && n_done == 1, "R3 height 255", n_draw, 255);

    // R2: back-to-back requests with a one-cycle release
    req(5, 5, 3);
    cyc(3);
    start = 1'b0;
    req(6, 9, 2);
    @(posedge clk); #2;
    chk(draw && y_out == 8'd9, "R2 back-to-back", int'(y_out), 9);
    cyc(5);
    chk(n_draw == 2, "R2 second line", n_draw, 2);

    // R7: start held through reset
    @(negedge clk); rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    n_draw = 0; n_done = 0;
    cyc(12);
    chk(n_draw == 0 && n_done == 0, "R7 start through reset", n_draw + n_done, 0);
    drop();
    cyc(2);
    req(8, 8, 1);
    drop();
    cyc(4);
    chk(n_draw == 1 && n_done == 1, "R7 rearmed after low", n_draw, 1);

    finish_up();
  end

endmodule